// File: doc/BRIEF.md
# Windowed Address Translation Table

This block holds a small set of programmable address-translation windows that sit between a 64-bit requesting address bus and a downstream bus. Software programs each window through a 32-bit register write port. A window has a 64-bit source base, a power-of-two size, an enable flag, a 64-bit translated base and a 24-bit attribute word. The attribute word tells the downstream side which kind of transaction to issue, for example configuration, I/O, memory or device access.

The lookup is purely combinational. An incoming address is compared against every enabled window at once, using all 64 bits. The lowest-numbered window that contains the address wins. Its translated base is combined with the address bits that fall inside the window, and its attribute word and direction bit are presented with a hit flag. When no window matches, the address passes through unchanged and the hit flag stays low. Each window's registers also read back combinationally on the register port.

Top module: `xwt_table`

## Requirements
- R1: After a synchronous active-low reset, every window is disabled, every register reads zero, and no lookup hits.
- R2: Window i occupies register bytes 0x20*i to 0x20*i+0x1F. The word offsets are 0x00 source low, 0x04 source high, 0x08 translated low, 0x0C translated high and 0x10 attribute, and a write lands one clock later. Offsets 0x14, 0x18, 0x1C and non-word-aligned offsets read zero, and writes to them change nothing.
- R3: In the source-low word, bit 0 enables the window, bits 6:1 hold a size code N giving a window of 2^(N+1) bytes, and bits 31:12 are source base bits 31:12. Bits 11:7 always read zero.
- R4: Translated-low bits 11:0 always read zero. Attribute bits 31:24 always read zero.
- R5: A window hits when it is enabled and the address equals the source base in every bit at or above bit N+1, compared over all 64 bits. N=63 covers the whole address space.
- R6: On a hit, the output address is the translated base OR the address bits below bit N+1.
- R7: When several enabled windows hit, the lowest-numbered one supplies the output.
- R8: On a miss, the hit flag is 0, the output address equals the input address, and the attribute and direction outputs are 0.
- R9: On a hit, the attribute output equals the winning window's 24-bit attribute word, and the direction output equals its bit 22.
- R10: Clearing a window's enable bit removes it from matching immediately, so a lower-priority window or pass-through takes over. Setting the bit brings the window back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address (log2(ENTRIES)+5 bits) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Combinational register read data at cfg_addr |
| lk_addr | input | 64 | Address to translate |
| lk_hit | output | 1 | A window matched |
| lk_addr_out | output | 64 | Translated or passed-through address |
| lk_attr | output | 24 | Attribute word of the winning window |
| lk_inbound | output | 1 | Attribute bit 22 of the winning window |

## Verification
The lookup is driven at the edges of every programmed window: the base, the last byte, one byte below and one byte past the end, and the midpoint. These addresses separate off-by-one errors in the mask from errors in the size code. A walking-one sweep over all 64 address bits, with and without a low base, shows whether the upper 32 bits take part in matching. Two pairs of windows are placed so that one lies inside the other, in both index orders, which exposes a wrong priority direction. A full-space window is enabled late to exercise the N=63 mask. Register readback with the reserved bits set checks the field masking.

// File: rtl/xwt_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the windowed address translation table.
// Assumes a 64-bit address space and 4 KiB minimum base alignment.
package xwt_pkg;
    localparam int ADDR_BITS = 64;
    localparam int ATTR_BITS = 24;
    localparam int DIR_BIT   = 22;

    localparam logic [4:0] OFF_SRC_LO = 5'h00;
    localparam logic [4:0] OFF_SRC_HI = 5'h04;
    localparam logic [4:0] OFF_TRN_LO = 5'h08;
    localparam logic [4:0] OFF_TRN_HI = 5'h0C;
    localparam logic [4:0] OFF_ATTR   = 5'h10;

    typedef struct packed {
        logic                 en;
        logic [5:0]           size_code;
        logic [19:0]          src_base_lo;
        logic [31:0]          src_base_hi;
        logic [19:0]          trn_base_lo;
        logic [31:0]          trn_base_hi;
        logic [ATTR_BITS-1:0] attr;
    } xwt_entry_t;

    // Mask of the in-window offset bits for size code N (window = 2^(N+1)).
    function automatic logic [ADDR_BITS-1:0] win_mask(input logic [5:0] code);
        logic [6:0] sh;
        sh = {1'b0, code} + 7'd1;
        if (sh == 7'd64) return '1;
        return (64'd1 << sh) - 64'd1;
    endfunction
endpackage

// File: rtl/xwt_entry_regs.sv
`timescale 1ns/1ps
// Register storage for one translation window.
// Decodes its own slice of the register space (index IDX, 0x20 stride).
// Assumes word-aligned accesses. Other offsets are ignored here.
module xwt_entry_regs
    import xwt_pkg::*;
#(
    parameter int IDX    = 0,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = IDX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output xwt_entry_t        ent
);
    logic       sel;
    logic [4:0] off;
    logic       unused_wbits;

    assign sel = (addr[ADDR_W-1:5] == IDX_W'(IDX));
    assign off = addr[4:0];
    assign unused_wbits = ^{wdata[11:7], wdata[31:24]};

    // Capture register writes addressed to this window; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent <= '0;
        end else if (we && sel) begin
            case (off)
                OFF_SRC_LO: begin
                    ent.en          <= wdata[0];
                    ent.size_code   <= wdata[6:1];
                    ent.src_base_lo <= wdata[31:12];
                end
                OFF_SRC_HI: ent.src_base_hi <= wdata;
                OFF_TRN_LO: ent.trn_base_lo <= wdata[31:12];
                OFF_TRN_HI: ent.trn_base_hi <= wdata;
                OFF_ATTR:   ent.attr        <= wdata[ATTR_BITS-1:0];
                default: ;
            endcase
        end
    end

    // R2: an attribute write appears in the window on the next cycle
    a_r2_attr_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel && off == OFF_ATTR) |=> (ent.attr == $past(wdata[ATTR_BITS-1:0])));
endmodule

// File: rtl/xwt_entry_match.sv
`timescale 1ns/1ps
// Containment test and address translation for one window.
// Assumes trn_base low 12 bits are zero (guaranteed by the register layout).
module xwt_entry_match
    import xwt_pkg::*;
(
    input  xwt_entry_t           ent,
    input  logic [ADDR_BITS-1:0] addr,
    output logic                 hit,
    output logic [ADDR_BITS-1:0] xaddr
);
    logic [ADDR_BITS-1:0] mask;
    logic [ADDR_BITS-1:0] src;
    logic [ADDR_BITS-1:0] trn;

    assign src = {ent.src_base_hi, ent.src_base_lo, 12'h000};
    assign trn = {ent.trn_base_hi, ent.trn_base_lo, 12'h000};

    // Compare the window-aligned part of the address and splice in the offset.
    always_comb begin
        mask  = win_mask(ent.size_code);
        hit   = ent.en && ((addr & ~mask) == (src & ~mask));
        xaddr = trn | (addr & mask);
    end
endmodule

// File: rtl/xwt_first_hit.sv
`timescale 1ns/1ps
// Fixed-priority selector: the lowest-numbered hitting window wins.
// Assumes N >= 2 so that the index has at least one bit.
module xwt_first_hit #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     hits,
    output logic [N-1:0]     grant,
    output logic             any,
    output logic [IDX_W-1:0] win
);
    // Scan from the top down so the lowest hitting index is assigned last.
    always_comb begin
        grant = '0;
        win   = '0;
        any   = |hits;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                win      = IDX_W'(i);
            end
        end
    end

    // R7: at most one window is granted
    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R7: the granted window really hit
    a_r7_grant_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (grant & hits) != '0);
endmodule

// File: rtl/xwt_table.sv
`timescale 1ns/1ps
// Windowed address translation table: ENTRIES programmable windows, a
// 32-bit register port and a combinational first-match lookup.
// Assumes ENTRIES >= 2. Register reads are combinational.
module xwt_table
    import xwt_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int ADDR_W = IDX_W + 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic [ADDR_BITS-1:0] lk_addr,
    output logic                 lk_hit,
    output logic [ADDR_BITS-1:0] lk_addr_out,
    output logic [ATTR_BITS-1:0] lk_attr,
    output logic                 lk_inbound
);
    xwt_entry_t           ents  [ENTRIES];
    logic [ADDR_BITS-1:0] xaddr [ENTRIES];
    logic [ENTRIES-1:0]   hits;
    logic [ENTRIES-1:0]   grant;
    logic                 any;
    logic [IDX_W-1:0]     win;
    logic [IDX_W-1:0]     ridx;
    logic                 unused_grant;

    assign unused_grant = ^grant;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_win
        xwt_entry_regs #(.IDX(g), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_regs (
            .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
            .wdata(cfg_wdata), .ent(ents[g])
        );
        xwt_entry_match i_match (
            .ent(ents[g]), .addr(lk_addr), .hit(hits[g]), .xaddr(xaddr[g])
        );
    end

    xwt_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) i_prio (
        .clk(clk), .rst_n(rst_n), .hits(hits), .grant(grant), .any(any), .win(win)
    );

    // Drive lookup outputs from the winner, or pass the address through.
    always_comb begin
        lk_hit      = any;
        lk_addr_out = any ? xaddr[win] : lk_addr;
        lk_attr     = any ? ents[win].attr : '0;
        lk_inbound  = any ? ents[win].attr[DIR_BIT] : 1'b0;
    end

    assign ridx = cfg_addr[ADDR_W-1:5];

    // Register readback with reserved fields forced to zero.
    always_comb begin
        cfg_rdata = '0;
        if (int'(ridx) < ENTRIES) begin
            case (cfg_addr[4:0])
                OFF_SRC_LO: cfg_rdata = {ents[ridx].src_base_lo, 5'b0,
                                         ents[ridx].size_code, ents[ridx].en};
                OFF_SRC_HI: cfg_rdata = ents[ridx].src_base_hi;
                OFF_TRN_LO: cfg_rdata = {ents[ridx].trn_base_lo, 12'h000};
                OFF_TRN_HI: cfg_rdata = ents[ridx].trn_base_hi;
                OFF_ATTR:   cfg_rdata = {8'h00, ents[ridx].attr};
                default:    cfg_rdata = '0;
            endcase
        end
    end

    // R1: the first cycle after reset release sees no hit
    a_r1_reset_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !lk_hit);
    // R8: a miss passes the address through with empty attributes
    a_r8_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_addr_out == lk_addr && lk_attr == '0 && !lk_inbound));
    // R6: the low 12 offset bits always survive a hit
    a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_addr_out[11:0] == lk_addr[11:0]));
    // R3: source-low bits 11:7 read zero
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr[4:0] == OFF_SRC_LO) |-> (cfg_rdata[11:7] == 5'b0));
    // R4: translated-low bits 11:0 read zero
    a_r4_trn_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr[4:0] == OFF_TRN_LO) |-> (cfg_rdata[11:0] == 12'h000));
endmodule

// File: tb/test_xwt_table.sv
`timescale 1ns/1ps
module test_xwt_table;
    localparam int E = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [63:0] lk_addr = '0;
    logic        lk_hit;
    logic [63:0] lk_addr_out;
    logic [23:0] lk_attr;
    logic        lk_inbound;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model of the programmed registers
    logic [31:0] m_slo [E];
    logic [31:0] m_shi [E];
    logic [31:0] m_tlo [E];
    logic [31:0] m_thi [E];
    logic [31:0] m_prm [E];

    xwt_table #(.ENTRIES(E)) i_xwt_table (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_addr_out(lk_addr_out), .lk_attr(lk_attr),
        .lk_inbound(lk_inbound)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] msk(input int n);
        if (n == 63) return '1;
        return (64'd1 << (n + 1)) - 64'd1;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a[4:0])
            5'h00: m_slo[a[7:5]] = d & 32'hFFFF_F07F;
            5'h04: m_shi[a[7:5]] = d;
            5'h08: m_tlo[a[7:5]] = d & 32'hFFFF_F000;
            5'h0C: m_thi[a[7:5]] = d;
            5'h10: m_prm[a[7:5]] = d & 32'h00FF_FFFF;
            default: ;
        endcase
    endtask

    task automatic prog(input int e, input logic [63:0] src, input int n, input bit en,
                        input logic [63:0] trn, input logic [23:0] prm);
        logic [7:0] b;
        b = 8'(e * 32);
        wr(b + 8'h00, (src[31:0] & 32'hFFFF_F000) | (32'(n) << 1) | 32'(en));
        wr(b + 8'h04, src[63:32]);
        wr(b + 8'h08, trn[31:0]);
        wr(b + 8'h0C, trn[63:32]);
        wr(b + 8'h10, {8'h00, prm});
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        logic [31:0] exp;
        cfg_addr = a;
        #1;
        case (a[4:0])
            5'h00: exp = m_slo[a[7:5]];
            5'h04: exp = m_shi[a[7:5]];
            5'h08: exp = m_tlo[a[7:5]];
            5'h0C: exp = m_thi[a[7:5]];
            5'h10: exp = m_prm[a[7:5]];
            default: exp = '0;
        endcase
        chk(tag, 64'(cfg_rdata), 64'(exp));
    endtask

    // model lookup and compare all outputs
    task automatic lk(input logic [63:0] a);
        bit hit;
        logic [63:0] oa;
        logic [23:0] at;
        hit = 1'b0; oa = a; at = '0;
        for (int e = 0; e < E; e++) begin
            logic [63:0] m;
            logic [63:0] s;
            m = msk(int'(m_slo[e][6:1]));
            s = {m_shi[e], m_slo[e][31:12], 12'h000};
            if (!hit && m_slo[e][0] && ((a & ~m) == (s & ~m))) begin
                hit = 1'b1;
                oa  = {m_thi[e], m_tlo[e]} | (a & m);
                at  = m_prm[e][23:0];
            end
        end
        lk_addr = a;
        #1;
        chk("R5 hit", 64'(lk_hit), 64'(hit));
        chk(hit ? "R6 addr" : "R8 passthru addr", lk_addr_out, oa);
        chk("R9 attr", 64'(lk_attr), 64'(at));
        chk("R9 dir", 64'(lk_inbound), 64'(at[22]));
    endtask

    task automatic edges(input int e);
        logic [63:0] m;
        logic [63:0] s;
        m = msk(int'(m_slo[e][6:1]));
        s = {m_shi[e], m_slo[e][31:12], 12'h000} & ~m;
        lk(s); lk(s | m); lk(s - 64'd1); lk((s | m) + 64'd1); lk(s | (m >> 1));
    endtask

    initial begin
        for (int e = 0; e < E; e++) begin
            m_slo[e] = '0; m_shi[e] = '0; m_tlo[e] = '0; m_thi[e] = '0; m_prm[e] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything reads zero and nothing hits after reset
        for (int a = 0; a < 256; a += 4) rd("R1 reset read", 8'(a));
        lk(64'h0); lk(64'hFFFF_FFFF_FFFF_FFFF); lk(64'h0000_0000_8000_0000);

        // program windows (R2/R3)
        prog(0, 64'h0000_0000_2C1C_0000, 11, 1, 64'h0000_0000_2C1C_0000, 24'h420004);
        prog(1, 64'h0000_0000_8000_0000, 30, 1, 64'h0000_0008_8000_0000, 24'h4E0004);
        prog(2, 64'h0000_0040_0000_0000, 32, 1, 64'h0000_0000_0000_0000, 24'h000000);
        prog(3, 64'h0000_0000_8000_0000, 15, 1, 64'h0000_0000_1234_0000, 24'h020000);
        prog(4, 64'h0000_0000_5F80_0000, 22, 1, 64'h0000_0000_5F80_0000, 24'h020000);
        prog(5, 64'h0000_0000_2C00_0000, 23, 1, 64'h0000_0000_7000_0000, 24'h000001);
        prog(6, 64'h0000_0000_0000_1000, 3, 1, 64'h0000_0000_0000_2000, 24'h400000);
        prog(7, 64'h0, 63, 0, 64'h0000_0001_0000_0000, 24'h123456);

        // R3/R4: reserved bits set in writes read back as zero
        wr(8'h00, 32'h2C1C_0F97);   // bits 11:7 set, N=11, en
        rd("R3 src low reserved", 8'h00);
        chk("R3 src low value", 64'(cfg_rdata), 64'h2C1C_0017);
        wr(8'h08, 32'h2C1C_0ABC);
        rd("R4 trn low", 8'h08);
        chk("R4 trn low value", 64'(cfg_rdata), 64'h2C1C_0000);
        wr(8'h10, 32'hFF42_0004);
        rd("R4 attr high", 8'h10);
        chk("R4 attr value", 64'(cfg_rdata), 64'h0042_0004);

        // R2: unmapped offsets read zero and writes change nothing
        wr(8'h14, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'h1D, 32'hFFFF_FFFF);
        rd("R2 unmapped 14", 8'h14);
        rd("R2 unmapped 1D", 8'h1D);
        rd("R2 unmapped 01", 8'h01);
        for (int a = 0; a < 256; a += 4) rd("R2 readback", 8'(a));

        // R6: explicit translation values
        lk(64'h0000_0040_1234_5678);
        chk("R6 upper window", lk_addr_out, 64'h0000_0000_1234_5678);
        lk(64'h0000_0000_8765_4321);
        chk("R6 2GiB window", lk_addr_out, 64'h0000_0008_8765_4321);
        lk(64'h0000_0000_0000_100F);
        chk("R6 16B window", lk_addr_out, 64'h0000_0000_0000_200F);
        lk(64'h0000_0000_0000_1010);
        chk("R8 past 16B window", 64'(lk_hit), 64'd0);

        // R7: nested windows in both index orders
        lk(64'h0000_0000_8000_1000);
        chk("R7 outer lower index", 64'(lk_attr), 64'h4E0004);
        lk(64'h0000_0000_2C1C_0004);
        chk("R7 inner lower index", 64'(lk_attr), 64'h420004);
        chk("R9 dir set", 64'(lk_inbound), 64'd1);
        lk(64'h0000_0000_2C1D_0004);
        chk("R7 outer only", 64'(lk_attr), 64'h000001);

        // R5/R6/R8: window edges and walking ones over all 64 bits
        for (int e = 0; e < 7; e++) edges(e);
        for (int b = 0; b < 64; b++) begin
            lk(64'd1 << b);
            lk((64'd1 << b) | 64'h0000_0000_8000_0000);
            lk((64'd1 << b) | 64'h0000_0040_0000_0000);
        end

        // R10: disable window 0, inner address falls to window 5
        wr(8'h00, 32'h2C1C_0016);
        lk(64'h0000_0000_2C1C_0004);
        chk("R10 disabled falls through", 64'(lk_attr), 64'h000001);
        chk("R10 addr via outer", lk_addr_out, 64'h0000_0000_701C_0004);
        // R10: disable window 1, nested window 3 now wins
        wr(8'h20, 32'h8000_003C);
        lk(64'h0000_0000_8000_1000);
        chk("R10 inner exposed", lk_addr_out, 64'h0000_0000_1234_1000);
        // R10: enable full-space window 7 (N=63)
        wr(8'hE0, 32'h0000_007F);
        lk(64'hFFFF_FFFF_FFFF_FFF0);
        chk("R10 full space hit", 64'(lk_hit), 64'd1);
        chk("R5 full space addr", lk_addr_out, 64'hFFFF_FFFF_FFFF_FFF0);
        for (int b = 0; b < 64; b++) lk(64'd1 << b);
        wr(8'hE0, 32'h0000_007E);
        lk(64'hFFFF_FFFF_FFFF_FFF0);
        chk("R10 re-disabled miss", 64'(lk_hit), 64'd0);

        // R1: reset again clears the table
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int e = 0; e < E; e++) begin
            m_slo[e] = '0; m_shi[e] = '0; m_tlo[e] = '0; m_thi[e] = '0; m_prm[e] = '0;
        end
        rd("R1 reset clears src", 8'h20);
        lk(64'h0000_0000_8000_1000);
        chk("R1 no hit after reset", 64'(lk_hit), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule